// File: doc/BRIEF.md
# Multi-Rate System Timer Unit

This block supplies three timekeeping services from one fast system clock. A chain of prescalers derives a 1 MHz step, a 1 kHz step and a 10 Hz step. The 1 MHz step advances a free-running 32-bit microsecond counter that software can read but never write. The 10 Hz step advances a time-of-day counter that software can overwrite at any time. The 1 kHz step raises a periodic interrupt flag, which stays set until software acknowledges it.

A simple synchronous register port reaches all three services. A request is one cycle of `bus_sel`, with `bus_wr` choosing a write or a read. Read data comes back registered one cycle later with `bus_rvalid`. Because the read data register captures the selected counter in a single edge, every read is coherent. The divide ratios are parameters: `BASE_DIV` is the number of system clocks per microsecond, `MS_DIV` is the number of microsecond steps per millisecond, and `TOD_DIV` is the number of millisecond steps per time-of-day step.

Top module: `rtimer_unit`

## Requirements
- R1: Address 0 reads the microsecond counter. After n clock edges with reset released it holds floor(n / BASE_DIV) modulo 2^32.
- R2: A write to address 0 has no effect, and the counter keeps following R1.
- R3: A write to address 1 loads `bus_wdata` into the time-of-day counter on the next clock edge. A read of address 1 returns the loaded value until the next time-of-day step.
- R4: The 1 kHz step occurs on every edge n where n is a multiple of BASE_DIV*MS_DIV. The time-of-day counter advances on every TOD_DIV-th 1 kHz step. Reset or a load restarts this count, so the first increment after a load comes on the TOD_DIV-th 1 kHz step strictly after the load edge.
- R5: Bit 0 of address 2 is the interrupt enable. It resets to 0, it is written through address 2, and it reads back. While it is 0, 1 kHz steps never set the interrupt flag.
- R6: While the enable is 1, each 1 kHz step sets the interrupt flag. `tick_irq` shows the flag, and bit 0 of a read of address 3 also shows it.
- R7: Once set, the flag stays set until a write of any value to address 3 clears it on the following edge.
- R8: If an acknowledge write and an enabled 1 kHz step fall on the same edge, the flag ends set.
- R9: `bus_rvalid` is high in the cycle after each read request and only then. Bits of addresses 2 and 3 other than bit 0 read as 0.
- R10: After reset, both counters read 0, the enable reads 0, `tick_irq` is 0 and `bus_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register request strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register index: 0 microseconds, 1 time of day, 2 control, 3 status/acknowledge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| tick_irq | output | 1 | Sticky 1 kHz interrupt flag |

## Verification
The bench builds the unit with BASE_DIV=4, MS_DIV=5 and TOD_DIV=3. With these values a 1 kHz step falls every 20 cycles and a time-of-day step every 60 cycles. Several interrupt periods, time-of-day increments before and after a load, and the edge where an acknowledge meets a step all fall within a few hundred cycles. Because the steps are this short, the exact edge timing can be checked against closed-form expectations derived from the cycle count since reset.

// File: rtl/rtimer_pkg.sv
// Shared definitions for the multi-rate timer unit.
// Assumes a two-bit register index; the index values are decoded by the
// register port and relied on by software.
package rtimer_pkg;

    typedef enum logic [1:0] {
        RIDX_USEC = 2'd0,   // free-running microsecond counter, read only
        RIDX_TOD  = 2'd1,   // loadable time-of-day counter
        RIDX_CTRL = 2'd2,   // bit 0: 1 kHz interrupt enable
        RIDX_STAT = 2'd3    // read: bit 0 flag; write: acknowledge
    } rtimer_ridx_e;

    localparam int RTIMER_DATA_W = 32;

endpackage

// File: rtl/rtimer_prescale.sv
// Prescaler stage: counts input steps and emits one output step
// (combinationally, coincident with the input step) every DIV input steps.
// Assumes DIV >= 1. A restart returns the phase to zero and suppresses
// any output in that cycle.
module rtimer_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step_in,
    output logic step_out
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // Output step on the last phase of the count
    always_comb begin
        step_out = step_in && (phase_q == LAST) && !restart;
    end

    // Advance the phase on each input step, wrapping at DIV
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (step_in) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtimer_count.sv
// Step counter with an optional synchronous load. A load takes priority
// over a step in the same cycle. Wraps modulo 2^W.
module rtimer_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);
    logic [W-1:0] value_q;

    // Load or advance the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (load) begin
            value_q <= load_val;
        end else if (step) begin
            value_q <= value_q + 1'b1;
        end
    end

    assign value = value_q;
endmodule

// File: rtl/rtimer_irq.sv
// Sticky periodic interrupt flag. An enabled step sets it; an acknowledge
// clears it. Assumes that a step must never be lost, so a set wins over
// an acknowledge in the same cycle.
module rtimer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic enable,
    input  logic ack,
    output logic flag
);
    logic flag_q;

    // Set on an enabled step, otherwise clear on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (step && enable) begin
            flag_q <= 1'b1;
        end else if (ack) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/rtimer_regs.sv
// Register port of the timer unit: decodes one-cycle requests, holds the
// enable bit, produces load and acknowledge strobes and registers read
// data one cycle after a read request. The read register samples the
// selected source on a single edge, so wide values are coherent.
module rtimer_regs
    import rtimer_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = RTIMER_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] usec,
    input  logic [DATA_W-1:0] tod,
    input  logic              flag,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              tod_load,
    output logic              irq_en,
    output logic              irq_ack
);
    logic              wr_req;
    logic              rd_req;
    logic              en_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rd_mux;

    // Split the strobe into read and write requests
    always_comb begin
        wr_req = sel && wr;
        rd_req = sel && !wr;
    end

    // Write strobes; writes to the microsecond index decode to nothing
    always_comb begin
        tod_load = wr_req && (addr == RIDX_TOD);
        irq_ack  = wr_req && (addr == RIDX_STAT);
    end

    // Select the read source
    always_comb begin
        unique case (addr)
            RIDX_USEC: rd_mux = usec;
            RIDX_TOD:  rd_mux = tod;
            RIDX_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, en_q};
            default:   rd_mux = {{(DATA_W-1){1'b0}}, flag};
        endcase
    end

    // Enable bit storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_req && (addr == RIDX_CTRL)) begin
            en_q <= wdata[0];
        end
    end

    // Capture read data and its valid in one edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_req;
            if (rd_req) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;
    assign irq_en = en_q;
endmodule

// File: rtl/rtimer_unit.sv
// Multi-rate timer unit top: cascaded prescalers off the system clock
// drive a free-running microsecond counter, a loadable time-of-day
// counter and a sticky 1 kHz interrupt flag, all behind a small register
// port. Assumes BASE_DIV system clocks make one microsecond.
module rtimer_unit
    import rtimer_pkg::*;
#(
    parameter int BASE_DIV = 100,
    parameter int MS_DIV   = 1000,
    parameter int TOD_DIV  = 100,
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = RTIMER_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              tick_irq
);
    logic              us_tick;
    logic              ms_tick;
    logic              tod_tick;
    logic              tod_load;
    logic              irq_en;
    logic              irq_ack;
    logic [DATA_W-1:0] usec;
    logic [DATA_W-1:0] tod;

    // System clock to 1 MHz
    rtimer_prescale #(.DIV(BASE_DIV)) u_div_us (
        .clk(clk), .rst_n(rst_n), .restart(1'b0),
        .step_in(1'b1), .step_out(us_tick)
    );

    // 1 MHz to 1 kHz
    rtimer_prescale #(.DIV(MS_DIV)) u_div_ms (
        .clk(clk), .rst_n(rst_n), .restart(1'b0),
        .step_in(us_tick), .step_out(ms_tick)
    );

    // 1 kHz to 10 Hz, restarted by a time-of-day load
    rtimer_prescale #(.DIV(TOD_DIV)) u_div_tod (
        .clk(clk), .rst_n(rst_n), .restart(tod_load),
        .step_in(ms_tick), .step_out(tod_tick)
    );

    // Free-running microsecond count; never loaded
    rtimer_count #(.W(DATA_W)) u_usec (
        .clk(clk), .rst_n(rst_n), .step(us_tick),
        .load(1'b0), .load_val('0), .value(usec)
    );

    // Time-of-day count
    rtimer_count #(.W(DATA_W)) u_tod (
        .clk(clk), .rst_n(rst_n), .step(tod_tick),
        .load(tod_load), .load_val(bus_wdata), .value(tod)
    );

    // Periodic interrupt flag
    rtimer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .step(ms_tick),
        .enable(irq_en), .ack(irq_ack), .flag(tick_irq)
    );

    // Register port
    rtimer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .usec(usec), .tod(tod), .flag(tick_irq),
        .rdata(bus_rdata), .rvalid(bus_rvalid),
        .tod_load(tod_load), .irq_en(irq_en), .irq_ack(irq_ack)
    );
endmodule

// File: rtl/rtimer_unit_chk.sv
// Temporal checks for the timer unit, bound onto its top.
module rtimer_unit_chk #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rvalid,
    input logic              tick_irq,
    input logic              us_tick,
    input logic              ms_tick,
    input logic              irq_en,
    input logic [DATA_W-1:0] usec,
    input logic [DATA_W-1:0] tod
);
    // R1: the microsecond count moves only on a 1 MHz step, by one
    p_usec_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !us_tick |=> $stable(usec));
    p_usec_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick |=> (usec == $past(usec) + 1'b1));

    // R3: a time-of-day write lands on the next edge
    p_tod_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> (tod == $past(bus_wdata)));

    // R5: with the enable low and the flag clear, the flag stays clear
    p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !tick_irq) |=> !tick_irq);

    // R6: an enabled 1 kHz step sets the flag
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && irq_en) |=> tick_irq);

    // R7: the flag holds without an acknowledge
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_irq && !(bus_sel && bus_wr && bus_addr == 2'd3)) |=> tick_irq);

    // R9: read valid follows each read request and nothing else
    p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);
    p_rvalid_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);
endmodule

bind rtimer_unit rtimer_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .tick_irq(tick_irq),
    .us_tick(us_tick), .ms_tick(ms_tick), .irq_en(irq_en),
    .usec(usec), .tod(tod)
);

// File: tb/tb_rtimer_unit.sv
module tb_rtimer_unit;
    localparam int B  = 4;
    localparam int M  = 5;
    localparam int T  = 3;
    localparam int BM = B * M;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    int tod_base = 0;
    int tod_edge = 0;
    bit en_model = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    rtimer_unit #(.BASE_DIV(B), .MS_DIV(M), .TOD_DIV(T)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .tick_irq(tick_irq)
    );

    always #2 clk = ~clk;

    // Edges counted since reset release
    always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] tod_at(input int m);
        return 32'(tod_base + ((m / BM) - (tod_edge / BM)) / T);
    endfunction

    // Driver: issue a read at a negedge and queue its expected value
    task automatic do_read(input logic [1:0] a, input string req, input int kind);
        logic [31:0] e;
        @(negedge clk);
        case (kind)
            0: e = 32'(ncyc / B);
            1: e = tod_at(ncyc);
            2: e = {31'b0, en_model};
            default: e = {31'b0, tick_irq};
        endcase
        exp_q.push_back(e);
        tag_q.push_back(req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        if (a == 2'd1) begin
            tod_base = int'(d);
            tod_edge = ncyc + 1;
        end
        if (a == 2'd2) en_model = d[0];
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 begin bus_sel = 1'b0; bus_wr = 1'b0; end
    endtask

    task automatic idle_until(input int target);
        while (ncyc < target) @(negedge clk);
    endtask

    task automatic wait_phase(input int ph);
        @(negedge clk);
        while ((ncyc % BM) != ph) @(negedge clk);
    endtask

    // Monitor: pop and compare each returned read
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 irq after reset", {31'b0, tick_irq}, 32'd0);
        check("R10 rvalid after reset", {31'b0, bus_rvalid}, 32'd0);
        do_read(2'd0, "R10 usec after reset", 0);
        do_read(2'd1, "R10 tod after reset", 1);
        do_read(2'd2, "R10 enable after reset", 2);
        // R1: counter at several offsets
        for (int i = 0; i < 6; i++) begin
            idle_until(ncyc + 3 + i);
            do_read(2'd0, "R1 usec value", 0);
        end
        // R5: disabled, two 1 kHz periods pass without a flag
        idle_until(45);
        check("R5 flag stays clear while disabled", {31'b0, tick_irq}, 32'd0);
        do_read(2'd3, "R5 status while disabled", 3);
        // R2: write to the counter index is ignored
        do_write(2'd0, 32'hDEAD_0000);
        do_read(2'd0, "R2 usec after write", 0);
        idle_until(ncyc + 7);
        do_read(2'd0, "R2 usec keeps counting", 0);
        // R3/R4: load just before a time-of-day step
        wait_phase(BM - 2);
        do_write(2'd1, 32'h0000_1000);
        do_read(2'd1, "R3 tod after load", 1);
        idle_until(ncyc + BM + 3);
        do_read(2'd1, "R4 tod no early step", 1);
        idle_until(ncyc + 2 * BM);
        do_read(2'd1, "R4 tod first step after load", 1);
        idle_until(ncyc + 3 * BM);
        do_read(2'd1, "R4 tod later step", 1);
        // R5/R6: enable and observe a set
        do_write(2'd2, 32'hFFFF_FFFF);
        do_read(2'd2, "R5 enable readback", 2);
        wait_phase(0);
        check("R6 flag set on 1 kHz step", {31'b0, tick_irq}, 32'd1);
        do_read(2'd3, "R6 status shows flag", 3);
        // R7: holds until acknowledged
        idle_until(ncyc + 8);
        check("R7 flag holds", {31'b0, tick_irq}, 32'd1);
        do_write(2'd3, 32'd0);
        @(negedge clk);
        check("R7 flag cleared by ack", {31'b0, tick_irq}, 32'd0);
        // R8: ack on the same edge as a step
        wait_phase(BM - 2);
        do_write(2'd3, 32'd0);
        @(negedge clk);
        check("R8 step beats ack", {31'b0, tick_irq}, 32'd1);
        // R5: disable, clear, no new set
        do_write(2'd2, 32'd0);
        do_write(2'd3, 32'd0);
        idle_until(ncyc + 2 * BM);
        check("R5 no set after disable", {31'b0, tick_irq}, 32'd0);
        do_read(2'd0, "R1 usec late", 0);
        do_read(2'd1, "R4 tod late", 1);
        repeat (3) @(negedge clk);
        check("R9 all reads returned", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule